// File: doc/BRIEF.md
# Compressed Instruction Expander

This block turns a 16-bit compressed instruction into the full 32-bit base instruction that means the same thing, so that a decoder built for 32-bit words can run compressed code unchanged. It covers all three compressed quadrants for integer work and for floating-point loads and stores. For each format it rebuilds the immediate from its scattered source bits, widens the 3-bit register fields, and flags reserved or undefined encodings as illegal.

The parameter `XLEN` (32 or 64) chooses the rules for the narrower or the wider machine. These rules differ in three places: the 011/111 memory slots, quadrant-1 funct3 001, and the 32-bit-result register forms. The parameter `REG_OUT` adds one register stage after the expander for timing. Fetch alignment, instruction buffering and execution are handled elsewhere.

Top module: `rvc_expander`

## Requirements
- R1: Quadrant 0 funct3 000 expands to ADDI rd', x2, imm with imm[9:6]=c[10:7], imm[5:4]=c[12:11], imm[3]=c[5], imm[2]=c[6]. A zero immediate, which includes the all-zero word, is illegal.
- R2: The other quadrant-0 slots are register-relative loads and stores with base x(8+c[9:7]) and data register x(8+c[4:2]). Word offsets are scaled by 4 and doubleword offsets by 8. Slots 011 and 111 are LD/SD when XLEN=64 and FLW/FSW when XLEN=32. Slot 100 is illegal.
- R3: Quadrant 1 funct3 000 gives ADDI rd,rd,imm and funct3 010 gives ADDI rd,x0,imm, both with the signed 6-bit immediate {c[12],c[6:2]}. Funct3 001 gives JAL x1 when XLEN=32. When XLEN=64 it gives ADDIW, and rd=0 is illegal.
- R4: Quadrant 1 funct3 011 with rd=2 gives ADDI x2,x2,imm, with the sign from c[12], imm[8:7]=c[4:3], imm[6]=c[5], imm[5]=c[2], imm[4]=c[6]. With any other rd it gives LUI with imm[17:12]={c[12],c[6:2]} sign-extended. A zero immediate is illegal in both forms.
- R5: Shifts and ANDI: SRLI and SRAI act on x(8+c[9:7]) and SLLI acts on rd, with shift amount {c[12],c[6:2]}. When XLEN=32 a set c[12] is illegal. ANDI uses the signed 6-bit immediate.
- R6: Quadrant 1 funct3 100 with c[11:10]=11 gives SUB/XOR/OR/AND for c[6:5]=00/01/10/11 when c[12]=0. When c[12]=1 it gives SUBW/ADDW for c[6:5]=00/01 on XLEN=64 only. Every other combination is illegal.
- R7: Funct3 101 is JAL x0. The offset is signed from c[12], with [10]=c[8], [9:8]=c[10:9], [7]=c[6], [6]=c[7], [5]=c[2], [4]=c[11], [3:1]=c[5:3].
- R8: Funct3 110/111 are BEQ/BNE of x(8+c[9:7]) against x0. The offset is signed from c[12], with [7:6]=c[6:5], [5]=c[2], [4:3]=c[11:10], [2:1]=c[4:3].
- R9: Quadrant 2 funct3 100 with c[12]=0: rs2=0 and rd≠0 gives JALR x0,0(rd), rs2≠0 gives ADDI rd,rs2,0, and rd=rs2=0 is illegal.
- R10: Quadrant 2 funct3 100 with c[12]=1: c[11:2]=0 gives EBREAK (0x00100073), rs2=0 gives JALR x1,0(rd), and otherwise ADD rd,rd,rs2.
- R11: Stack-relative memory accesses use base x2. LWSP is illegal with rd=0, and so is LDSP on XLEN=64. Slots 011/111 are LDSP/SDSP on XLEN=64 and FLWSP/FSWSP on XLEN=32. FLDSP/FSDSP are always present.
- R12: A word with c[1:0]=11 is illegal. Whenever the illegal flag is set the output word is 0. Every legal output has bits 1:0 = 11.
- R13: With REG_OUT=1 the result appears one clock after the input. During reset the outputs are word 0 with the illegal flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output stage |
| rst_ni | input | 1 | Synchronous active-low reset |
| cinstr_i | input | 16 | Compressed instruction |
| instr_o | output | 32 | Expanded instruction, 0 when illegal |
| illegal_o | output | 1 | Reserved or undefined encoding |

## Verification
The bench sweeps every one of the 65,536 input words through a 64-bit registered instance and a 32-bit combinational instance. It compares each result with an expansion computed from arithmetic offsets, so a misplaced immediate bit yields a wrong jump, branch or memory offset for about half of all codes. The reserved cases are checked both ways: zero immediates in the stack-adjust and upper-immediate forms, rd=0 in the stack loads and ADDIW, and the empty jump-register case. A design that missed one would emit a bogus instruction instead of trapping, and one that over-flagged would trap on a legal hint. The width-dependent slots and shift amounts catch a design that mixes up the two machine widths, and periodic checks of the registered copy just after an input change catch a missing or doubled pipeline stage.

// File: rtl/rvc_pkg.sv
`timescale 1ns/1ps
// Shared types and format packers for the compressed instruction expander.
// Assumes the standard 32-bit base instruction formats.
package rvc_pkg;
    localparam logic [6:0] OPC_LOAD     = 7'h03;
    localparam logic [6:0] OPC_LOAD_FP  = 7'h07;
    localparam logic [6:0] OPC_OP_IMM   = 7'h13;
    localparam logic [6:0] OPC_OP_IMM32 = 7'h1B;
    localparam logic [6:0] OPC_STORE    = 7'h23;
    localparam logic [6:0] OPC_STORE_FP = 7'h27;
    localparam logic [6:0] OPC_OP       = 7'h33;
    localparam logic [6:0] OPC_LUI      = 7'h37;
    localparam logic [6:0] OPC_OP32     = 7'h3B;
    localparam logic [6:0] OPC_BRANCH   = 7'h63;
    localparam logic [6:0] OPC_JALR     = 7'h67;
    localparam logic [6:0] OPC_JAL      = 7'h6F;
    localparam logic [31:0] WORD_EBREAK = 32'h0010_0073;

    // Every immediate a compressed word can carry, already reassembled.
    typedef struct packed {
        logic [11:0] ci;     // signed 6-bit, sign-extended
        logic [11:0] spn;    // stack-pointer add, unsigned
        logic [11:0] wofs;   // register-relative word offset
        logic [11:0] dofs;   // register-relative doubleword offset
        logic [11:0] wsp_ld; // stack word load offset
        logic [11:0] dsp_ld; // stack doubleword load offset
        logic [11:0] wsp_st; // stack word store offset
        logic [11:0] dsp_st; // stack doubleword store offset
        logic [11:0] sp16;   // stack adjust by multiples of 16
        logic [19:0] upper;  // upper immediate
        logic [20:1] jofs;   // jump offset
        logic [12:1] bofs;   // branch offset
        logic [5:0]  shamt;  // shift amount
    } rvc_imm_t;

    function automatic logic [31:0] pack_i(logic [11:0] imm, logic [4:0] rs1,
                                           logic [2:0] f3, logic [4:0] rd, logic [6:0] op);
        return {imm, rs1, f3, rd, op};
    endfunction

    function automatic logic [31:0] pack_s(logic [11:0] imm, logic [4:0] rs2, logic [4:0] rs1,
                                           logic [2:0] f3, logic [6:0] op);
        return {imm[11:5], rs2, rs1, f3, imm[4:0], op};
    endfunction

    function automatic logic [31:0] pack_r(logic [6:0] f7, logic [4:0] rs2, logic [4:0] rs1,
                                           logic [2:0] f3, logic [4:0] rd, logic [6:0] op);
        return {f7, rs2, rs1, f3, rd, op};
    endfunction

    function automatic logic [31:0] pack_b(logic [12:1] ofs, logic [4:0] rs1, logic [2:0] f3);
        return {ofs[12], ofs[10:5], 5'd0, rs1, f3, ofs[4:1], ofs[11], OPC_BRANCH};
    endfunction

    function automatic logic [31:0] pack_j(logic [20:1] ofs, logic [4:0] rd);
        return {ofs[20], ofs[10:1], ofs[11], ofs[19:12], rd, OPC_JAL};
    endfunction
endpackage

// File: rtl/rvc_imm_gen.sv
`timescale 1ns/1ps
// Reassembles every compressed immediate from the scrambled source bits.
// Assumes: pure wiring, no decode; the decoder picks the field it needs.
module rvc_imm_gen
    import rvc_pkg::*;
(
    input  logic [12:2] c_i,
    output rvc_imm_t    imm_o
);
    logic s;
    assign s = c_i[12];

    // Build each immediate by its own bit permutation.
    always_comb begin
        imm_o.ci     = {{6{s}}, s, c_i[6:2]};
        imm_o.spn    = {2'b00, c_i[10:7], c_i[12:11], c_i[5], c_i[6], 2'b00};
        imm_o.wofs   = {5'd0, c_i[5], c_i[12:10], c_i[6], 2'b00};
        imm_o.dofs   = {4'd0, c_i[6:5], c_i[12:10], 3'b000};
        imm_o.wsp_ld = {4'd0, c_i[3:2], s, c_i[6:4], 2'b00};
        imm_o.dsp_ld = {3'd0, c_i[4:2], s, c_i[6:5], 3'b000};
        imm_o.wsp_st = {4'd0, c_i[8:7], c_i[12:9], 2'b00};
        imm_o.dsp_st = {3'd0, c_i[9:7], c_i[12:10], 3'b000};
        imm_o.sp16   = {{3{s}}, c_i[4:3], c_i[5], c_i[2], c_i[6], 4'd0};
        imm_o.upper  = {{14{s}}, s, c_i[6:2]};
        imm_o.jofs   = {{10{s}}, c_i[8], c_i[10:9], c_i[6], c_i[7], c_i[2], c_i[11], c_i[5:3]};
        imm_o.bofs   = {{5{s}}, c_i[6:5], c_i[2], c_i[11:10], c_i[4:3]};
        imm_o.shamt  = {s, c_i[6:2]};
    end
endmodule

// File: rtl/rvc_decode.sv
`timescale 1ns/1ps
// Selects the 32-bit equivalent of a compressed word and flags reserved codes.
// Assumes immediates come prebuilt from rvc_imm_gen; output word is 0 if illegal.
module rvc_decode
    import rvc_pkg::*;
#(
    parameter int XLEN = 64
)(
    input  logic [15:0] c_i,
    input  rvc_imm_t    imm_i,
    output logic [31:0] word_o,
    output logic        ill_o
);
    localparam bit WIDE = (XLEN == 64);

    logic [4:0]  rd, rs2, rdp, rs1p;
    logic [2:0]  f3;
    logic [31:0] raw;
    logic        ill;

    assign rd   = c_i[11:7];
    assign rs2  = c_i[6:2];
    assign rdp  = {2'b01, c_i[4:2]};
    assign rs1p = {2'b01, c_i[9:7]};
    assign f3   = c_i[15:13];

    // Main decode: one branch per quadrant and funct3 slot.
    always_comb begin
        raw = 32'd0;
        ill = 1'b0;
        unique case (c_i[1:0])
            2'b00: begin
                unique case (f3)
                    3'b000: begin
                        raw = pack_i(imm_i.spn, 5'd2, 3'b000, rdp, OPC_OP_IMM);
                        ill = (c_i[12:5] == 8'd0);
                    end
                    3'b001: raw = pack_i(imm_i.dofs, rs1p, 3'b011, rdp, OPC_LOAD_FP);
                    3'b010: raw = pack_i(imm_i.wofs, rs1p, 3'b010, rdp, OPC_LOAD);
                    3'b011: raw = WIDE ? pack_i(imm_i.dofs, rs1p, 3'b011, rdp, OPC_LOAD)
                                       : pack_i(imm_i.wofs, rs1p, 3'b010, rdp, OPC_LOAD_FP);
                    3'b100: ill = 1'b1;
                    3'b101: raw = pack_s(imm_i.dofs, rdp, rs1p, 3'b011, OPC_STORE_FP);
                    3'b110: raw = pack_s(imm_i.wofs, rdp, rs1p, 3'b010, OPC_STORE);
                    default: raw = WIDE ? pack_s(imm_i.dofs, rdp, rs1p, 3'b011, OPC_STORE)
                                        : pack_s(imm_i.wofs, rdp, rs1p, 3'b010, OPC_STORE_FP);
                endcase
            end
            2'b01: begin
                unique case (f3)
                    3'b000: raw = pack_i(imm_i.ci, rd, 3'b000, rd, OPC_OP_IMM);
                    3'b001: begin
                        if (WIDE) begin
                            raw = pack_i(imm_i.ci, rd, 3'b000, rd, OPC_OP_IMM32);
                            ill = (rd == 5'd0);
                        end else begin
                            raw = pack_j(imm_i.jofs, 5'd1);
                        end
                    end
                    3'b010: raw = pack_i(imm_i.ci, 5'd0, 3'b000, rd, OPC_OP_IMM);
                    3'b011: begin
                        ill = (c_i[12] == 1'b0) && (c_i[6:2] == 5'd0);
                        if (rd == 5'd2) raw = pack_i(imm_i.sp16, 5'd2, 3'b000, 5'd2, OPC_OP_IMM);
                        else            raw = {imm_i.upper, rd, OPC_LUI};
                    end
                    3'b100: begin
                        unique case (c_i[11:10])
                            2'b00: begin
                                raw = pack_i({6'b000000, imm_i.shamt}, rs1p, 3'b101, rs1p, OPC_OP_IMM);
                                ill = !WIDE && c_i[12];
                            end
                            2'b01: begin
                                raw = pack_i({6'b010000, imm_i.shamt}, rs1p, 3'b101, rs1p, OPC_OP_IMM);
                                ill = !WIDE && c_i[12];
                            end
                            2'b10: raw = pack_i(imm_i.ci, rs1p, 3'b111, rs1p, OPC_OP_IMM);
                            default: begin
                                if (!c_i[12]) begin
                                    unique case (c_i[6:5])
                                        2'b00: raw = pack_r(7'h20, rdp, rs1p, 3'b000, rs1p, OPC_OP);
                                        2'b01: raw = pack_r(7'h00, rdp, rs1p, 3'b100, rs1p, OPC_OP);
                                        2'b10: raw = pack_r(7'h00, rdp, rs1p, 3'b110, rs1p, OPC_OP);
                                        default: raw = pack_r(7'h00, rdp, rs1p, 3'b111, rs1p, OPC_OP);
                                    endcase
                                end else if (WIDE && !c_i[6]) begin
                                    raw = pack_r(c_i[5] ? 7'h00 : 7'h20, rdp, rs1p, 3'b000, rs1p, OPC_OP32);
                                end else begin
                                    ill = 1'b1;
                                end
                            end
                        endcase
                    end
                    3'b101: raw = pack_j(imm_i.jofs, 5'd0);
                    3'b110: raw = pack_b(imm_i.bofs, rs1p, 3'b000);
                    default: raw = pack_b(imm_i.bofs, rs1p, 3'b001);
                endcase
            end
            2'b10: begin
                unique case (f3)
                    3'b000: begin
                        raw = pack_i({6'b000000, imm_i.shamt}, rd, 3'b001, rd, OPC_OP_IMM);
                        ill = !WIDE && c_i[12];
                    end
                    3'b001: raw = pack_i(imm_i.dsp_ld, 5'd2, 3'b011, rd, OPC_LOAD_FP);
                    3'b010: begin
                        raw = pack_i(imm_i.wsp_ld, 5'd2, 3'b010, rd, OPC_LOAD);
                        ill = (rd == 5'd0);
                    end
                    3'b011: begin
                        if (WIDE) begin
                            raw = pack_i(imm_i.dsp_ld, 5'd2, 3'b011, rd, OPC_LOAD);
                            ill = (rd == 5'd0);
                        end else begin
                            raw = pack_i(imm_i.wsp_ld, 5'd2, 3'b010, rd, OPC_LOAD_FP);
                        end
                    end
                    3'b100: begin
                        if (!c_i[12]) begin
                            if (rs2 == 5'd0) begin
                                raw = pack_i(12'd0, rd, 3'b000, 5'd0, OPC_JALR);
                                ill = (rd == 5'd0);
                            end else begin
                                raw = pack_i(12'd0, rs2, 3'b000, rd, OPC_OP_IMM);
                            end
                        end else if (rs2 == 5'd0) begin
                            raw = (rd == 5'd0) ? WORD_EBREAK
                                               : pack_i(12'd0, rd, 3'b000, 5'd1, OPC_JALR);
                        end else begin
                            raw = pack_r(7'h00, rs2, rd, 3'b000, rd, OPC_OP);
                        end
                    end
                    3'b101: raw = pack_s(imm_i.dsp_st, rs2, 5'd2, 3'b011, OPC_STORE_FP);
                    3'b110: raw = pack_s(imm_i.wsp_st, rs2, 5'd2, 3'b010, OPC_STORE);
                    default: raw = WIDE ? pack_s(imm_i.dsp_st, rs2, 5'd2, 3'b011, OPC_STORE)
                                        : pack_s(imm_i.wsp_st, rs2, 5'd2, 3'b010, OPC_STORE_FP);
                endcase
            end
            default: ill = 1'b1;
        endcase
    end

    // Blank the word for any illegal code.
    assign word_o = ill ? 32'd0 : raw;
    assign ill_o  = ill;
endmodule

// File: rtl/rvc_out_stage.sv
`timescale 1ns/1ps
// Optional output register; a wire when REG_OUT is 0.
// Assumes synchronous active-low reset; reset value is "illegal, word 0".
module rvc_out_stage #(
    parameter bit REG_OUT = 1'b1
)(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic [31:0] word_i,
    input  logic        ill_i,
    output logic [31:0] word_o,
    output logic        ill_o
);
    generate
        if (REG_OUT) begin : g_reg
            // Capture the expansion once per clock.
            always_ff @(posedge clk_i) begin
                if (!rst_ni) begin
                    word_o <= 32'd0;
                    ill_o  <= 1'b1;
                end else begin
                    word_o <= word_i;
                    ill_o  <= ill_i;
                end
            end
        end else begin : g_wire
            logic unused_clk;
            assign unused_clk = clk_i ^ rst_ni;
            assign word_o = word_i;
            assign ill_o  = ill_i;
        end
    endgenerate
endmodule

// File: rtl/rvc_expander.sv
`timescale 1ns/1ps
// Top of the compressed instruction expander: immediate rebuild, decode,
// optional output register. Assumes XLEN is 32 or 64.
module rvc_expander
    import rvc_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter bit REG_OUT = 1'b1
)(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic [15:0] cinstr_i,
    output logic [31:0] instr_o,
    output logic        illegal_o
);
    rvc_imm_t    imm;
    logic [31:0] dec_word;
    logic        dec_ill;

    rvc_imm_gen u_imm (.c_i(cinstr_i[12:2]), .imm_o(imm));

    rvc_decode #(.XLEN(XLEN)) u_dec (
        .c_i(cinstr_i), .imm_i(imm), .word_o(dec_word), .ill_o(dec_ill)
    );

    rvc_out_stage #(.REG_OUT(REG_OUT)) u_out (
        .clk_i(clk_i), .rst_ni(rst_ni), .word_i(dec_word), .ill_i(dec_ill),
        .word_o(instr_o), .ill_o(illegal_o)
    );

    assert_illegal_blank_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        illegal_o |-> (instr_o == 32'd0));
    assert_legal_full_width_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !illegal_o |-> (instr_o[1:0] == 2'b11));
    assert_quad3_flagged_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cinstr_i[1:0] == 2'b11) |-> dec_ill);
    assert_zero_word_flagged_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cinstr_i == 16'd0) |-> dec_ill);
    assert_empty_jr_flagged_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cinstr_i[1:0] == 2'b10 && cinstr_i[15:12] == 4'b1000 && cinstr_i[11:2] == 10'd0) |-> dec_ill);

    generate
        if (XLEN == 64) begin : g_chk64
            assert_addiw_rd0_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (cinstr_i[1:0] == 2'b01 && cinstr_i[15:13] == 3'b001 && cinstr_i[11:7] == 5'd0)
                |-> dec_ill);
        end
        if (REG_OUT) begin : g_chk_reg
            assert_one_cycle_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
                rst_ni |=> (instr_o == $past(dec_word)) && (illegal_o == $past(dec_ill)));
        end
    endgenerate
endmodule

// File: tb/rvc_expander_tb.sv
`timescale 1ns/1ps
module rvc_expander_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cin = 16'd0;
    logic [31:0] w64, w32;
    logic        i64, i32;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    rvc_expander #(.XLEN(64), .REG_OUT(1'b1)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .cinstr_i(cin), .instr_o(w64), .illegal_o(i64));
    rvc_expander #(.XLEN(32), .REG_OUT(1'b0)) u_dut32 (
        .clk_i(clk), .rst_ni(rst_n), .cinstr_i(cin), .instr_o(w32), .illegal_o(i32));

    function automatic logic [31:0] fi(int imm, int rs1, int f3, int rd, int op);
        logic [31:0] t = imm;
        return {t[11:0], 5'(rs1), 3'(f3), 5'(rd), 7'(op)};
    endfunction
    function automatic logic [31:0] fs(int imm, int rs2, int rs1, int f3, int op);
        logic [31:0] t = imm;
        return {t[11:5], 5'(rs2), 5'(rs1), 3'(f3), t[4:0], 7'(op)};
    endfunction
    function automatic logic [31:0] fr(int f7, int rs2, int rs1, int f3, int rd, int op);
        return {7'(f7), 5'(rs2), 5'(rs1), 3'(f3), 5'(rd), 7'(op)};
    endfunction

    // Reference expansion from the requirements: {illegal, word}.
    function automatic logic [32:0] ref_exp(logic [15:0] c, bit wide);
        int rd = c[11:7], rs2 = c[6:2], rdp = 8 + c[4:2], rs1p = 8 + c[9:7];
        int sg = c[12] ? 1 : 0;
        int ci = c[6:2] - 32 * sg;
        int sh = c[6:2] + 32 * sg;
        int spn = c[10:7]*64 + c[12:11]*16 + c[5]*8 + c[6]*4;
        int wo = c[5]*64 + c[12:10]*8 + c[6]*4;
        int dof = c[6:5]*64 + c[12:10]*8;
        int wl = c[3:2]*64 + sg*32 + c[6:4]*4;
        int dl = c[4:2]*64 + sg*32 + c[6:5]*8;
        int ws = c[8:7]*64 + c[12:9]*4;
        int ds = c[9:7]*64 + c[12:10]*8;
        int s16 = c[4:3]*128 + c[5]*64 + c[2]*32 + c[6]*16 - 512*sg;
        int jo = c[8]*1024 + c[10:9]*256 + c[6]*128 + c[7]*64 + c[2]*32 + c[11]*16 + c[5:3]*2 - 2048*sg;
        int bo = c[6:5]*64 + c[2]*32 + c[11:10]*8 + c[4:3]*2 - 256*sg;
        logic [31:0] w = 32'd0, jt = jo, bt = bo, ut = ci;
        bit il = 1'b0;
        logic [31:0] jw = {jt[20], jt[10:1], jt[11], jt[19:12], 5'd0, 7'h6F};
        logic [31:0] bw = {bt[12], bt[10:5], 5'd0, 5'(rs1p), 3'd0, bt[4:1], bt[11], 7'h63};
        case ({c[1:0], c[15:13]})
            5'b00_000: begin w = fi(spn, 2, 0, rdp, 'h13); il = (spn == 0); end
            5'b00_001: w = fi(dof, rs1p, 3, rdp, 'h07);
            5'b00_010: w = fi(wo, rs1p, 2, rdp, 'h03);
            5'b00_011: w = wide ? fi(dof, rs1p, 3, rdp, 'h03) : fi(wo, rs1p, 2, rdp, 'h07);
            5'b00_100: il = 1'b1;
            5'b00_101: w = fs(dof, rdp, rs1p, 3, 'h27);
            5'b00_110: w = fs(wo, rdp, rs1p, 2, 'h23);
            5'b00_111: w = wide ? fs(dof, rdp, rs1p, 3, 'h23) : fs(wo, rdp, rs1p, 2, 'h27);
            5'b01_000: w = fi(ci, rd, 0, rd, 'h13);
            5'b01_001: if (wide) begin w = fi(ci, rd, 0, rd, 'h1B); il = (rd == 0); end
                       else begin w = jw; w[11:7] = 5'd1; end
            5'b01_010: w = fi(ci, 0, 0, rd, 'h13);
            5'b01_011: begin
                il = (ci == 0);
                w = (rd == 2) ? fi(s16, 2, 0, 2, 'h13) : {ut[19:0], 5'(rd), 7'h37};
            end
            5'b01_100: case (c[11:10])
                2'b00: begin w = fi(sh, rs1p, 5, rs1p, 'h13); il = !wide && sg == 1; end
                2'b01: begin w = fi(sh + 1024, rs1p, 5, rs1p, 'h13); il = !wide && sg == 1; end
                2'b10: w = fi(ci, rs1p, 7, rs1p, 'h13);
                default: if (sg == 0) begin
                    case (c[6:5])
                        2'b00: w = fr('h20, rdp, rs1p, 0, rs1p, 'h33);
                        2'b01: w = fr(0, rdp, rs1p, 4, rs1p, 'h33);
                        2'b10: w = fr(0, rdp, rs1p, 6, rs1p, 'h33);
                        default: w = fr(0, rdp, rs1p, 7, rs1p, 'h33);
                    endcase
                end else if (wide && c[6:5] == 2'b00) w = fr('h20, rdp, rs1p, 0, rs1p, 'h3B);
                else if (wide && c[6:5] == 2'b01) w = fr(0, rdp, rs1p, 0, rs1p, 'h3B);
                else il = 1'b1;
            endcase
            5'b01_101: w = jw;
            5'b01_110: w = bw;
            5'b01_111: begin w = bw; w[12] = 1'b1; end
            5'b10_000: begin w = fi(sh, rd, 1, rd, 'h13); il = !wide && sg == 1; end
            5'b10_001: w = fi(dl, 2, 3, rd, 'h07);
            5'b10_010: begin w = fi(wl, 2, 2, rd, 'h03); il = (rd == 0); end
            5'b10_011: if (wide) begin w = fi(dl, 2, 3, rd, 'h03); il = (rd == 0); end
                       else w = fi(wl, 2, 2, rd, 'h07);
            5'b10_100: if (sg == 0) begin
                if (rs2 == 0) begin w = fi(0, rd, 0, 0, 'h67); il = (rd == 0); end
                else w = fi(0, rs2, 0, rd, 'h13);
            end else begin
                if (rs2 == 0 && rd == 0) w = 32'h0010_0073;
                else if (rs2 == 0) w = fi(0, rd, 0, 1, 'h67);
                else w = fr(0, rs2, rd, 0, rd, 'h33);
            end
            5'b10_101: w = fs(ds, rs2, 2, 3, 'h27);
            5'b10_110: w = fs(ws, rs2, 2, 2, 'h23);
            5'b10_111: w = wide ? fs(ds, rs2, 2, 3, 'h23) : fs(ws, rs2, 2, 2, 'h27);
            default: il = 1'b1;
        endcase
        if (il) w = 32'd0;
        return {il, w};
    endfunction

    function automatic string req_of(logic [15:0] c);
        case ({c[1:0], c[15:13]})
            5'b00_000: return "R1";
            5'b01_000, 5'b01_001, 5'b01_010: return "R3";
            5'b01_011: return "R4";
            5'b01_100: return (c[11:10] == 2'b11) ? "R6" : "R5";
            5'b01_101: return "R7";
            5'b01_110, 5'b01_111: return "R8";
            5'b10_000: return "R5";
            5'b10_100: return c[12] ? "R10" : "R9";
            default: return (c[1:0] == 2'b00) ? "R2" : (c[1:0] == 2'b10) ? "R11" : "R12";
        endcase
    endfunction

    task automatic check(string req, string what, logic [32:0] got, logic [32:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got ill=%0b word=%08h, expected ill=%0b word=%08h",
                     req, what, got[32], got[31:0], exp[32], exp[31:0]);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R13", "reset state", {i64, w64}, {1'b1, 32'd0});
        rst_n = 1'b1;
        for (int i = 0; i < 65536; i++) begin
            cin = 16'(i);
            #1;
            if (i > 0 && (i % 1024) == 0)
                check("R13", "registered hold", {i64, w64}, ref_exp(16'(i - 1), 1'b1));
            @(posedge clk);
            @(negedge clk);
            check(req_of(cin), "rv64 sweep", {i64, w64}, ref_exp(cin, 1'b1));
            check(req_of(cin), "rv32 sweep", {i32, w32}, ref_exp(cin, 1'b0));
        end
        // R12: explicit full-width codes stay illegal with a blank word.
        cin = 16'hFFFF;
        @(posedge clk);
        @(negedge clk);
        check("R12", "quadrant 3", {i64, w64}, {1'b1, 32'd0});
        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R13 watchdog: got hang, expected completion");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule